// File: doc/BRIEF.md
# Word/Byte Selectable ROM Read Port

This block is a register-held model of a read-only memory read port. The contents are 16 bits wide and can be read either as whole words or as single bytes. In byte mode, one extra low-order address input chooses which half of the addressed word is returned. In that mode the top data pin acts as an address input, so it is not driven as an output.

Reads are gated by two active-low enables. The chip enable selects the device, and the output enable opens the lanes. Each data lane has its own enable bit, which stands in for a tri-state pin. An identification strobe replaces the array with two fixed signature words, and address bit 0 picks between them.

A write port is provided so that contents can be preloaded. It can only clear bits, which models cells that can be programmed but not restored. Every read result is registered, so it appears one clock after its inputs.

Top module: `wb_rom_port`

## Requirements
- R1: While reset is held, `dout` is 0 and every bit of `lane_oe` is 0.
- R2: A location that has never been written reads back as 0xFFFF.
- R3: A write stores old AND `wr_data`, so a write can only clear bits. A second write to the same location leaves the AND of both data values.
- R4: With `word_mode`=1, `ce_n`=0 and `oe_n`=0, `dout` carries the whole addressed word, including bit 15, and `lane_oe` is 0xFFFF.
- R5: With `word_mode`=0, enabled, and `byte_hi`=0, `dout[7:0]` is bits 7..0 of the addressed word.
- R6: With `word_mode`=0, enabled, and `byte_hi`=1, `dout[7:0]` is bits 15..8 of the addressed word.
- R7: In byte mode, `lane_oe` is 0x00FF and `dout[15:8]` is 0. Lane 15 is treated as an address input.
- R8: With `ce_n`=1, `lane_oe` is 0 and `dout` is 0 whatever the values of `oe_n` and the other inputs.
- R9: With `ce_n`=0 and `oe_n`=1, `lane_oe` is 0 and `dout` is 0.
- R10: With `id_mode`=1, the word read is 0x1E1E when `addr[0]`=0 and 0xF8F8 when `addr[0]`=1. The other address bits and the array contents are ignored. Lane and width rules R4 to R7 apply to this word.
- R11: Outputs change only at the clock edge that follows an input change, giving a latency of exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | ADDR_W | Word address |
| byte_hi | input | 1 | Byte-select address bit (byte mode) |
| word_mode | input | 1 | 1 = word reads, 0 = byte reads |
| ce_n | input | 1 | Active-low chip enable |
| oe_n | input | 1 | Active-low output enable |
| id_mode | input | 1 | Signature read strobe |
| wr_en | input | 1 | Program-write strobe |
| wr_addr | input | ADDR_W | Program-write address |
| wr_data | input | 16 | Program data (ANDed into the cell) |
| dout | output | 16 | Registered read data |
| lane_oe | output | 16 | Per-lane output enable |

## Verification
Directed reads of erased cells and of cells written twice show whether bits can only be cleared. Reading the same word in word mode and with each byte select shows whether the halves are swapped or lanes are mis-enabled. Enable patterns that separate standby from output-disable, each paired with address changes, show which enable actually gates the lanes. Signature reads with arbitrary upper address bits check that the array is bypassed. A seeded random mix of all inputs is then compared against a bench reference model.

// File: rtl/wb_rom_port.sv
module wb_rom_port #(
  parameter int ADDR_W = 8,
  parameter logic [15:0] MFR_CODE = 16'h1E1E,
  parameter logic [15:0] DEV_CODE = 16'hF8F8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              byte_hi,
  input  logic              word_mode,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              id_mode,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [15:0]       wr_data,
  output logic [15:0]       dout,
  output logic [15:0]       lane_oe
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [15:0] mem [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '1;
    end else if (wr_en) begin
      mem[wr_addr] <= mem[wr_addr] & wr_data;
    end
  end

  wire [15:0] word_sel = id_mode ? (addr[0] ? DEV_CODE : MFR_CODE) : mem[addr];
  wire [7:0]  byte_sel = byte_hi ? word_sel[15:8] : word_sel[7:0];
  wire        active   = !ce_n && !oe_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dout    <= '0;
      lane_oe <= '0;
    end else if (!active) begin
      dout    <= '0;
      lane_oe <= '0;
    end else if (word_mode) begin
      dout    <= word_sel;
      lane_oe <= 16'hFFFF;
    end else begin
      dout    <= {8'h00, byte_sel};
      lane_oe <= 16'h00FF;
    end
  end
endmodule

// File: rtl/wb_rom_port_checker.sv
module wb_rom_port_checker #(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] addr,
  input logic              word_mode,
  input logic              ce_n,
  input logic              oe_n,
  input logic              id_mode,
  input logic [15:0]       dout,
  input logic [15:0]       lane_oe
);
  logic seen;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) seen <= 1'b0; else seen <= 1'b1;

  always_comb if (!rst_n) AST_RESET_QUIET: assert (lane_oe == '0); // R1

  AST_STANDBY_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    seen && $past(ce_n) |-> lane_oe == '0 && dout == '0); // R8
  AST_OE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    seen && !$past(ce_n) && $past(oe_n) |-> lane_oe == '0); // R9
  AST_WORD_LANES: assert property (@(posedge clk) disable iff (!rst_n)
    seen && !$past(ce_n) && !$past(oe_n) && $past(word_mode) |-> lane_oe == 16'hFFFF); // R4
  AST_BYTE_LANES: assert property (@(posedge clk) disable iff (!rst_n)
    seen && !$past(ce_n) && !$past(oe_n) && !$past(word_mode) |-> lane_oe == 16'h00FF && dout[15:8] == 8'h00); // R7
  AST_ID_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    seen && !$past(ce_n) && !$past(oe_n) && $past(word_mode) && $past(id_mode)
    |-> dout == ($past(addr[0]) ? 16'hF8F8 : 16'h1E1E)); // R10
endmodule

bind wb_rom_port wb_rom_port_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .addr(addr), .word_mode(word_mode), .ce_n(ce_n),
  .oe_n(oe_n), .id_mode(id_mode), .dout(dout), .lane_oe(lane_oe));

// File: tb/wb_rom_port_bench.sv
module wb_rom_port_bench;
  localparam int CLK_P = 10;
  localparam int AW = 8;
  localparam int DEPTH = 1 << AW;

  logic clk = 0, rst_n = 0;
  logic [AW-1:0] addr = '0, wr_addr = '0;
  logic byte_hi = 0, word_mode = 1, ce_n = 1, oe_n = 1, id_mode = 0, wr_en = 0;
  logic [15:0] wr_data = '0;
  logic [15:0] dout, lane_oe;

  int checks = 0, fails = 0;
  bit done = 0;
  logic [15:0] model [DEPTH];

  always #(CLK_P/2) clk = ~clk;

  wb_rom_port #(.ADDR_W(AW)) u_wb_rom_port (
    .clk(clk), .rst_n(rst_n), .addr(addr), .byte_hi(byte_hi), .word_mode(word_mode),
    .ce_n(ce_n), .oe_n(oe_n), .id_mode(id_mode), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .dout(dout), .lane_oe(lane_oe));

  function automatic logic [15:0] exp_word();
    if (id_mode) return addr[0] ? 16'hF8F8 : 16'h1E1E;
    return model[addr];
  endfunction

  function automatic logic [15:0] exp_dout();
    logic [15:0] w = exp_word();
    if (ce_n || oe_n) return 16'h0;
    if (word_mode) return w;
    return {8'h00, byte_hi ? w[15:8] : w[7:0]};
  endfunction

  function automatic logic [15:0] exp_oe();
    if (ce_n || oe_n) return 16'h0;
    return word_mode ? 16'hFFFF : 16'h00FF;
  endfunction

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [AW-1:0] a, logic [15:0] d);
    @(negedge clk);
    wr_en = 1; wr_addr = a; wr_data = d;
    model[a] = model[a] & d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic rd(string req, logic [AW-1:0] a, logic bh, logic wm,
                    logic ce, logic oe, logic id);
    logic [15:0] ed, eo;
    @(negedge clk);
    addr = a; byte_hi = bh; word_mode = wm; ce_n = ce; oe_n = oe; id_mode = id;
    ed = exp_dout(); eo = exp_oe();
    @(posedge clk); #1;
    chk(req, dout, ed);
    chk(req, lane_oe, eo);
  endtask

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    for (int i = 0; i < DEPTH; i++) model[i] = 16'hFFFF;
    repeat (3) @(posedge clk); #1;
    chk("R1 dout", dout, 16'h0);
    chk("R1 lane_oe", lane_oe, 16'h0);
    @(negedge clk); rst_n = 1;

    rd("R2 erased", 8'h33, 0, 1, 0, 0, 0);
    wr(8'h10, 16'hA5C3);
    wr(8'h10, 16'hF0FF);
    rd("R3 and-write", 8'h10, 0, 1, 0, 0, 0);
    chk("R3 value", dout, 16'hA0C3);
    wr(8'h11, 16'h8001);
    rd("R4 word bit15", 8'h11, 0, 1, 0, 0, 0);
    rd("R5 low byte", 8'h10, 0, 0, 0, 0, 0);
    rd("R6 high byte", 8'h10, 1, 0, 0, 0, 0);
    chk("R7 lanes", lane_oe, 16'h00FF);
    rd("R8 standby oe low", 8'h10, 0, 1, 1, 0, 0);
    rd("R8 standby oe high", 8'h11, 1, 0, 1, 1, 0);
    rd("R9 output disable", 8'h10, 0, 1, 0, 1, 0);
    rd("R10 mfr", 8'h00, 0, 1, 0, 0, 1);
    rd("R10 dev", 8'hFE + 8'h01, 0, 1, 0, 0, 1);
    rd("R10 dev byte hi", 8'h01, 1, 0, 0, 0, 1);
    rd("R10 mfr byte lo", 8'h80, 0, 0, 0, 0, 1);

    rd("R11 setup", 8'h10, 0, 1, 0, 0, 0);
    @(negedge clk); addr = 8'h11;
    #1 chk("R11 hold before edge", dout, 16'hA0C3);
    @(posedge clk); #1 chk("R11 after edge", dout, 16'h8001);

    for (int i = 0; i < 40; i++) wr(8'($urandom), 16'($urandom));
    for (int i = 0; i < 400; i++)
      rd("R4-R10 random", 8'($urandom), 1'($urandom), 1'($urandom),
         ($urandom % 5) == 0, ($urandom % 5) == 0, ($urandom % 6) == 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule